// File: doc/BRIEF.md
# Receive Byte Buffer with Status Reporting

This block sits between a serial receiver and a register-mapped host. Each byte the receiver delivers is kept either in a circular queue of `DEPTH` entries or, when queueing is switched off, in a single holding register. The host reads bytes out through a data-read strobe. It sees a packed occupancy word, a data-ready flag and a sticky error word that clears when it is read. Two single-cycle event pulses report a dropped byte and an empty-queue read to an interrupt controller.

A four-state machine decides what happens in each cycle: `ST_HOLD` (queueing off), `ST_EMPTY`, `ST_PART` (some bytes held, not full) and `ST_FULL`. The named transitions are:

- **enable:** `ST_HOLD` goes to `ST_EMPTY`, `ST_PART` or `ST_FULL`, according to how many bytes the queue already holds.
- **disable:** any state goes to `ST_HOLD`.
- **first store:** `ST_EMPTY` goes to `ST_PART`.
- **fill:** `ST_PART` goes to `ST_FULL` when a store reaches `DEPTH`.
- **drain:** `ST_FULL` goes to `ST_PART` on a read.
- **last read:** `ST_PART` goes to `ST_EMPTY`.
- **flush:** any enabled state goes to `ST_EMPTY`.

A line break counts as a received byte of value 0x00.

Top module: `rxbuf_status`

## Requirements
- R1: After reset, `ctl_q`, `fifo_stat`, `err_stat`, `data_ready`, `ovf_pulse` and `udf_pulse` are all zero, and queueing is off.
- R2: With queueing on (`ctl_q[0]`=1), stored bytes come out oldest first. `rd_data` shows the oldest byte in the same cycle as `rd_data_stb`, and the pointers wrap after `DEPTH` entries.
- R3: `fifo_stat[7:0]` is the number of queued bytes and `fifo_stat[8]` is the full flag. When `DEPTH` bytes are held, the word reads 0x100: the count field is zero and only bit 8 is set.
- R4: With queueing on, `data_ready` is 1 exactly when at least one byte is queued.
- R5: A data read while queueing is on and the queue is empty returns 0x00, leaves the queue unchanged, and raises `udf_pulse` for one cycle on the next cycle.
- R6: A store into a full queue with no read in the same cycle drops the byte. It sets `err_stat` bit 0 (overrun) and raises `ovf_pulse` on the next cycle, and `data_ready` stays 1.
- R7: A read and a store in the same cycle leave the count unchanged, including when the queue is full. The new byte is queued behind the ones already held.
- R8: A control write (`ctl_wr`) loads the enable from `ctl_en_in`. With `ctl_flush_in`=1 it also empties the queue, and any read or store in that same cycle is discarded. `ctl_q` reads {0, enable}, so the flush bit always reads back 0.
- R9: With queueing off, a received byte overwrites the holding register and sets `data_ready`. A read returns the held byte and clears `data_ready`, unless a byte arrives in the same cycle.
- R10: `brk_evt` stores 0x00 in whichever store is active and sets `err_stat` bit 3. A byte offered in the same cycle is not stored.
- R11: `err_stat` bit 1 (parity) and bit 2 (frame) are set when `rx_valid` arrives with `rx_par_err` or `rx_frm_err`. The error bits accumulate. `rd_err_stb` returns the current word and clears it on the next cycle, keeping only bits set by events in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity error flag with the byte |
| rx_frm_err | input | 1 | Framing error flag with the byte |
| brk_evt | input | 1 | Line break detected |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_en_in | input | 1 | Queue enable value written |
| ctl_flush_in | input | 1 | Self-clearing flush request |
| ctl_q | output | 2 | Control readback {0, enable} |
| rd_data_stb | input | 1 | Host read of the data register |
| rd_data | output | 8 | Byte returned for the read |
| data_ready | output | 1 | A byte is available |
| rd_err_stb | input | 1 | Host read of the error word |
| fifo_stat | output | 9 | {full, count} occupancy word |
| err_stat | output | 4 | {break, frame, parity, overrun} |
| ovf_pulse | output | 1 | Byte dropped, one cycle |
| udf_pulse | output | 1 | Empty-queue read, one cycle |

## Verification
The bench builds the block with `DEPTH`=4. At that depth, the full state, the zero count field at full and pointer wrap-around are all reached after a handful of bytes. Overrun drops and reads combined with stores at full therefore occur many times in the random phase rather than once. Random phases that toggle the enable and issue flushes move the state machine through every named transition, including enabling over a queue that is already partly filled.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_EMPTY = 2'd1,
        ST_PART  = 2'd2,
        ST_FULL  = 2'd3
    } rxq_state_e;

    localparam int ERR_OVR = 0;
    localparam int ERR_PAR = 1;
    localparam int ERR_FRM = 2;
    localparam int ERR_BRK = 3;
    localparam int ERR_W   = 4;
    localparam int CNT_FLD = 8;
endpackage

// File: rtl/rxbuf_ring.sv
module rxbuf_ring #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] head,
    output logic [AW:0]   cnt
);
    logic [AW-1:0]       wp;
    logic [AW-1:0]       rp;
    logic [DEPTH*DW-1:0] flat;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            logic [DW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= '0;
                else if (push && !flush && wp == AW'(i))
                    q <= din;
            end
            assign flat[i*DW +: DW] = q;
        end
    endgenerate

    assign head = flat[rp*DW +: DW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
        end
    end
endmodule

// File: rtl/rxbuf_errlog.sv
module rxbuf_errlog
    import rxbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [ERR_W-1:0] set,
    output logic [ERR_W-1:0] err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            err <= '0;
        else
            err <= (clr ? '0 : err) | set;
    end
endmodule

// File: rtl/rxbuf_status.sv
module rxbuf_status
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rx_par_err,
    input  logic       rx_frm_err,
    input  logic       brk_evt,
    input  logic       ctl_wr,
    input  logic       ctl_en_in,
    input  logic       ctl_flush_in,
    output logic [1:0] ctl_q,
    input  logic       rd_data_stb,
    output logic [7:0] rd_data,
    output logic       data_ready,
    input  logic       rd_err_stb,
    output logic [8:0] fifo_stat,
    output logic [3:0] err_stat,
    output logic       ovf_pulse,
    output logic       udf_pulse
);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    rxq_state_e  st_q, st_d;
    logic        en_q, en_d;
    logic        flush, push_req, push, pop, drop, underrun;
    logic        hold_load, hold_clr, hold_vld;
    logic [7:0]  push_val, head, hold_q;
    logic [AW:0] cnt, cnt_d;
    logic [ERR_W-1:0] err_set;

    assign flush    = ctl_wr & ctl_flush_in;
    assign push_req = rx_valid | brk_evt;
    assign push_val = brk_evt ? 8'h00 : rx_byte;

    rxbuf_ring #(.DEPTH(DEPTH), .DW(8)) u_ring (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
        .din(push_val), .head(head), .cnt(cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_HOLD;
            en_q <= 1'b0;
        end else begin
            st_q <= st_d;
            en_q <= en_d;
        end
    end

    // Per-state datapath decisions and outputs
    always_comb begin
        pop        = 1'b0;
        push       = 1'b0;
        drop       = 1'b0;
        underrun   = 1'b0;
        hold_load  = 1'b0;
        hold_clr   = 1'b0;
        rd_data    = 8'h00;
        data_ready = 1'b0;
        unique case (st_q)
            ST_HOLD: begin
                rd_data    = hold_q;
                data_ready = hold_vld;
                hold_load  = push_req;
                hold_clr   = rd_data_stb;
            end
            ST_EMPTY: begin
                underrun = rd_data_stb;
                push     = push_req & ~flush;
            end
            ST_PART: begin
                rd_data    = head;
                data_ready = 1'b1;
                pop        = rd_data_stb & ~flush;
                push       = push_req & ~flush;
            end
            ST_FULL: begin
                rd_data    = head;
                data_ready = 1'b1;
                pop        = rd_data_stb & ~flush;
                push       = push_req & rd_data_stb & ~flush;
                drop       = push_req & ~rd_data_stb & ~flush;
            end
        endcase
    end

    // Next state from the occupancy the cycle leaves behind
    always_comb begin
        en_d  = ctl_wr ? ctl_en_in : en_q;
        cnt_d = flush ? '0 : cnt + (AW+1)'(push) - (AW+1)'(pop);
        if (!en_d)
            st_d = ST_HOLD;
        else if (cnt_d == '0)
            st_d = ST_EMPTY;
        else if (cnt_d == FULL_CNT)
            st_d = ST_FULL;
        else
            st_d = ST_PART;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= 8'h00;
            hold_vld  <= 1'b0;
            ovf_pulse <= 1'b0;
            udf_pulse <= 1'b0;
        end else begin
            if (hold_load) begin
                hold_q   <= push_val;
                hold_vld <= 1'b1;
            end else if (hold_clr) begin
                hold_vld <= 1'b0;
            end
            ovf_pulse <= drop;
            udf_pulse <= underrun;
        end
    end

    always_comb begin
        err_set          = '0;
        err_set[ERR_OVR] = drop;
        err_set[ERR_PAR] = rx_valid & rx_par_err;
        err_set[ERR_FRM] = rx_valid & rx_frm_err;
        err_set[ERR_BRK] = brk_evt;
    end

    rxbuf_errlog u_err (
        .clk(clk), .rst_n(rst_n), .clr(rd_err_stb), .set(err_set), .err(err_stat)
    );

    assign fifo_stat = (cnt == FULL_CNT) ? {1'b1, 8'h00} : {1'b0, CNT_FLD'(cnt)};
    assign ctl_q     = {1'b0, en_q};
endmodule

// File: rtl/rxbuf_status_chk.sv
module rxbuf_status_chk
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_data_stb,
    input logic        rx_valid,
    input logic        brk_evt,
    input logic        ctl_wr,
    input logic [1:0]  ctl_q,
    input logic [8:0]  fifo_stat,
    input logic        data_ready,
    input logic [3:0]  err_stat,
    input logic        ovf_pulse,
    input logic        udf_pulse,
    input rxq_state_e  st,
    input logic [AW:0] cnt
);
    // R3
    full_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_stat[8] |-> fifo_stat[7:0] == 8'h00);

    // R3
    state_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FULL) |-> cnt == (AW+1)'(DEPTH));

    // R3
    full_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[0] && cnt == (AW+1)'(DEPTH)) |-> st == ST_FULL);

    // R4
    ready_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[0] |-> data_ready == (cnt != '0));

    // R5
    underflow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        udf_pulse |-> $past(rd_data_stb && ctl_q[0] && cnt == '0));

    // R6
    overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (err_stat[0] && $past(st == ST_FULL)));

    // R7
    rd_store_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[0] && !ctl_wr && rd_data_stb && (rx_valid || brk_evt) && cnt != '0)
        |=> $stable(cnt));
endmodule

bind rxbuf_status rxbuf_status_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_data_stb(rd_data_stb), .rx_valid(rx_valid),
    .brk_evt(brk_evt), .ctl_wr(ctl_wr), .ctl_q(ctl_q), .fifo_stat(fifo_stat),
    .data_ready(data_ready), .err_stat(err_stat), .ovf_pulse(ovf_pulse),
    .udf_pulse(udf_pulse), .st(st_q), .cnt(cnt)
);

// File: tb/sim_rxbuf_status.sv
`timescale 1ns/1ps
module sim_rxbuf_status;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 0, rx_par_err = 0, rx_frm_err = 0, brk_evt = 0;
    logic [7:0] rx_byte = 8'h00;
    logic       ctl_wr = 0, ctl_en_in = 0, ctl_flush_in = 0;
    logic       rd_data_stb = 0, rd_err_stb = 0;
    logic [1:0] ctl_q;
    logic [7:0] rd_data;
    logic       data_ready, ovf_pulse, udf_pulse;
    logic [8:0] fifo_stat;
    logic [3:0] err_stat;

    always #4 clk = ~clk;

    rxbuf_status #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .brk_evt(brk_evt),
        .ctl_wr(ctl_wr), .ctl_en_in(ctl_en_in), .ctl_flush_in(ctl_flush_in),
        .ctl_q(ctl_q), .rd_data_stb(rd_data_stb), .rd_data(rd_data),
        .data_ready(data_ready), .rd_err_stb(rd_err_stb), .fifo_stat(fifo_stat),
        .err_stat(err_stat), .ovf_pulse(ovf_pulse), .udf_pulse(udf_pulse)
    );

    int vectors = 0;
    int errors  = 0;
    string ctx = "";

    bit         en_m = 0;
    logic [7:0] q_m[$];
    logic [7:0] hold_m = 8'h00;
    bit         hvld_m = 0;
    logic [3:0] err_m = 4'h0;

    function automatic logic [8:0] exp_stat();
        if (q_m.size() == DEPTH) return 9'h100;
        return 9'(q_m.size());
    endfunction

    function automatic logic exp_ready();
        return en_m ? (q_m.size() != 0) : hvld_m;
    endfunction

    function automatic logic [7:0] exp_rd();
        if (!en_m) return hold_m;
        return (q_m.size() != 0) ? q_m[0] : 8'h00;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", tag, ctx, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [7:0] b, input bit par, input bit frm,
                        input bit brk, input bit cw, input bit cen, input bit cfl,
                        input bit rd, input bit rde);
        logic [7:0] bv;
        logic [3:0] setb;
        bit exp_ovf, exp_udf, push;
        @(negedge clk);
        rx_valid = v; rx_byte = b; rx_par_err = par; rx_frm_err = frm; brk_evt = brk;
        ctl_wr = cw; ctl_en_in = cen; ctl_flush_in = cfl;
        rd_data_stb = rd; rd_err_stb = rde;
        #1;
        check("R3 status word", 32'(fifo_stat), 32'(exp_stat()));
        check(en_m ? "R4 data_ready" : "R9 data_ready", 32'(data_ready), 32'(exp_ready()));
        check("R11 error word", 32'(err_stat), 32'(err_m));
        check("R8 control readback", 32'(ctl_q), {30'd0, 1'b0, en_m});
        if (rd)
            check(!en_m ? "R9 hold data" : (q_m.size() == 0 ? "R5 empty read data" : "R2 read data"),
                  32'(rd_data), 32'(exp_rd()));
        bv = brk ? 8'h00 : b;
        push = v | brk;
        setb = {brk, v & frm, v & par, 1'b0};
        exp_ovf = 0; exp_udf = 0;
        if (en_m) begin
            if (rd && q_m.size() == 0) exp_udf = 1;
            if (!(cw && cfl)) begin
                if (rd && q_m.size() > 0) void'(q_m.pop_front());
                if (push) begin
                    if (q_m.size() < DEPTH) q_m.push_back(bv);
                    else begin exp_ovf = 1; setb[0] = 1'b1; end
                end
            end
        end else begin
            if (push) begin hold_m = bv; hvld_m = 1; end
            else if (rd) hvld_m = 0;
        end
        if (cw && cfl) q_m.delete();
        err_m = (rde ? 4'h0 : err_m) | setb;
        if (cw) en_m = cen;
        @(posedge clk); #1;
        check("R6 overflow pulse", 32'(ovf_pulse), 32'(exp_ovf));
        check("R5 underflow pulse", 32'(udf_pulse), 32'(exp_udf));
    endtask

    task automatic push_b(input logic [7:0] b); step(1, b, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic rd_b(); step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0); endtask
    task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        ctx = "R1 reset";
        check("R1 status", 32'(fifo_stat), 0);
        check("R1 ready", 32'(data_ready), 0);
        check("R1 errors", 32'(err_stat), 0);
        check("R1 control", 32'(ctl_q), 0);
        check("R1 pulses", {30'd0, ovf_pulse, udf_pulse}, 0);
        rst_n = 1'b1;
        idle();

        ctx = "R9 holding register";
        push_b(8'hA5); push_b(8'h3C); rd_b(); rd_b();
        step(1, 8'h77, 0, 0, 0, 0, 0, 0, 1, 0);
        rd_b();

        ctx = "R10 break in hold mode";
        step(1, 8'h99, 0, 0, 1, 0, 0, 0, 0, 0); rd_b();

        ctx = "R8 enable with flush";
        step(0, 0, 0, 0, 0, 1, 1, 1, 0, 1); idle();

        ctx = "R5 empty read";
        rd_b(); idle();

        ctx = "R3 R6 fill and overflow";
        for (int i = 0; i < DEPTH + 2; i++) push_b(8'h10 + 8'(i));
        idle();

        ctx = "R7 read and store at full";
        step(1, 8'hEE, 0, 0, 0, 0, 0, 0, 1, 0);
        step(1, 8'hEF, 0, 0, 0, 0, 0, 0, 1, 0);

        ctx = "R2 drain with wrap";
        for (int i = 0; i < DEPTH + 1; i++) rd_b();

        ctx = "R10 R11 break parity frame";
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        step(1, 8'h42, 1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 8'h43, 0, 1, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        idle(); rd_b(); rd_b();

        ctx = "R8 flush with pending store";
        push_b(8'h55); push_b(8'h56);
        step(1, 8'h57, 0, 0, 0, 1, 1, 1, 1, 0);
        idle();

        ctx = "R4 enable over filled queue";
        push_b(8'h61); push_b(8'h62);
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        push_b(8'h63);
        step(0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
        rd_b(); rd_b(); rd_b();

        ctx = "random R2 R7";
        for (int n = 0; n < 4000; n++) begin
            bit v, brk, cw, rd, rde;
            v   = ($urandom % 100) < 45;
            brk = ($urandom % 100) < 3;
            rd  = ($urandom % 100) < 35;
            rde = ($urandom % 100) < 10;
            cw  = ($urandom % 100) < 3;
            step(v, 8'($urandom), ($urandom % 10) == 0, ($urandom % 10) == 0, brk,
                 cw, ($urandom % 100) < 85, ($urandom % 100) < 30, rd, rde);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule